// File: doc/BRIEF.md
# Audio Interrupt Protocol Router

This block collects interrupt requests from the legacy audio sub-functions of a sound controller, here a MIDI UART receiver and a sound DSP, and delivers them on one of three signalling schemes. Each request pulse sets a pending bit. A pending bit stays set until software writes a one to that bit of the status port, or until the source acknowledges it through its own ack input. Per-source enables decide which pending bits may raise an interrupt. The MIDI enable has two extra qualifiers: the MIDI function must be switched on, and legacy address decode must be off.

Two control bits pick the protocol. With the serialized enable set, the block watches the shared serial interrupt pin for a start frame and then counts 3-clock slots. It pulls the pin low in the first clock of the slot whose number equals the routed IRQ. With the serialized enable clear, the mode bit picks between an active-low level line for a PCI-style bus and a one-hot bank of five active-high legacy lines. The legacy line, and the serial slot number, both come from one 3-bit routing field.

Top module: `audio_irq_router`

## Requirements
- R1: A one-cycle pulse on `src_req[i]` sets pending bit i in the next cycle. The bit stays set until it is cleared, whether or not the source is enabled.
- R2: A pending bit is cleared by a status write (`sts_wr`=1) with the matching `sts_wmask` bit set, or by `src_ack[i]`. Writes with a zero mask bit have no effect. If a new request and a clear arrive in the same cycle, the bit stays set.
- R3: `pend_status` shows the pending bits, with bit 0 for MIDI and bit 1 for the DSP. `dsp_flag` reads 8'h01 while the DSP bit is pending and 8'h00 otherwise; its upper seven bits are always 0.
- R4: Protocol select: `serirq_en`=1 selects serialized delivery whatever `irq_mode` is. Otherwise `irq_mode`=0 selects the level line and `irq_mode`=1 selects the legacy lines. Only the selected protocol ever signals.
- R5: In level-line mode, `inta_n` is 0 while any enabled source is pending, and 1 otherwise. In every other mode it is 1.
- R6: In legacy mode, while an enabled source is pending, `route_sel` codes 0,1,2,3,4 drive `irq_lines` bit 0..4 (IRQ 5, 7, 9, 10, 11) high, and only that bit. Codes 5 to 7 drive no line. All lines are low otherwise.
- R7: The MIDI source (index 0) counts as enabled only when `src_en[0]`=1, `uart_fn_en`=1 and `legacy_decode`=0.
- R8: A serial frame starts when `serirq_i` has been sampled low for at least 4 clocks and is then sampled high. Slot 0 begins in the next cycle, each of the 16 slots lasts 3 clocks, and a low run shorter than 4 clocks starts no frame.
- R9: In serialized mode, `serirq_oe` is 1 for exactly the first clock of the slot numbered by the routed IRQ (5, 7, 9, 10 or 11), and only while an enabled source is pending. An invalid route code drives no slot.
- R10: A pending bit of a disabled source raises nothing. Enabling that source later raises the interrupt at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | NSRC | Request pulses from the sub-functions (0 MIDI, 1 DSP) |
| src_ack | input | NSRC | Per-source acknowledge, clears its pending bit |
| src_en | input | NSRC | Per-source interrupt enables |
| uart_fn_en | input | 1 | MIDI UART function enabled |
| legacy_decode | input | 1 | Legacy address decode on; blocks the MIDI enable |
| irq_mode | input | 1 | 0 level line, 1 legacy lines (when serial off) |
| serirq_en | input | 1 | Selects serialized delivery |
| route_sel | input | 3 | Legacy IRQ routing code |
| sts_wr | input | 1 | Status write strobe |
| sts_wmask | input | NSRC | Write-one-to-clear mask |
| pend_status | output | NSRC | Pending bits |
| dsp_flag | output | 8 | DSP interrupt flag byte |
| inta_n | output | 1 | Active-low level interrupt |
| irq_lines | output | 5 | Legacy lines IRQ 5, 7, 9, 10, 11 |
| serirq_i | input | 1 | Sampled serial interrupt pin |
| serirq_oe | output | 1 | Drive serial pin low when 1 |

## Verification
The assertions check the following on every cycle: only one protocol signals at a time, and the legacy bank is never more than one-hot. A request always lands in its pending bit, and a pending bit only disappears through a write or an acknowledge. A serial drive never lasts more than one clock, and a frame opens only after the pin is seen high. Some behaviours depend on exact values that only the bench knows, so only its scenarios can show them. These are the mapping from each route code to its line and its slot position, the MIDI gating through the function and decode bits, the rejection of a short start pulse, and the rule that a request wins over a simultaneous clear.

// File: rtl/audio_irq_pkg.sv
package audio_irq_pkg;

    typedef enum logic [1:0] {
        PROTO_LEVEL  = 2'd0,
        PROTO_LEGACY = 2'd1,
        PROTO_SERIAL = 2'd2
    } proto_e;

    localparam int NUM_LINES = 5;

    function automatic logic route_valid(input logic [2:0] code);
        return code < 3'd5;
    endfunction

    function automatic logic [3:0] route_to_irq(input logic [2:0] code);
        logic [3:0] irq;
        case (code)
            3'd0:    irq = 4'd5;
            3'd1:    irq = 4'd7;
            3'd2:    irq = 4'd9;
            3'd3:    irq = 4'd10;
            3'd4:    irq = 4'd11;
            default: irq = 4'd0;
        endcase
        return irq;
    endfunction

endpackage

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] ack,
    input  logic            wr,
    input  logic [NSRC-1:0] wmask,
    output logic [NSRC-1:0] pend
);

    typedef struct packed {
        logic [NSRC-1:0] pend;
    } bank_t;

    bank_t st_q, st_d;

    always_comb begin
        logic [NSRC-1:0] clr;
        clr       = ack | (wr ? wmask : '0);
        st_d      = st_q;
        st_d.pend = (st_q.pend & ~clr) | req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;

    for (genvar i = 0; i < NSRC; i++) begin : g_chk
        p_req_sets_r1 : assert property (@(posedge clk) disable iff (!rst_n)
            req[i] |=> pend[i]);
        p_hold_r1 : assert property (@(posedge clk) disable iff (!rst_n)
            (pend[i] && !ack[i] && !(wr && wmask[i])) |=> pend[i]);
        p_ack_clears_r2 : assert property (@(posedge clk) disable iff (!rst_n)
            (ack[i] && !req[i]) |=> !pend[i]);
    end

endmodule

// File: rtl/irq_serial_slotter.sv
module irq_serial_slotter #(
    parameter int START_MIN = 4,
    parameter int SLOT_CLKS = 3,
    parameter int NUM_SLOTS = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         enable,
    input  logic                         pin_i,
    input  logic                         want,
    input  logic [$clog2(NUM_SLOTS)-1:0] irq_num,
    output logic                         drive_o
);

    localparam int CW = $clog2(START_MIN + 1);
    localparam int SW = $clog2(NUM_SLOTS);
    localparam int PW = $clog2(SLOT_CLKS);
    localparam logic [CW-1:0] START_CNT = CW'(START_MIN);
    localparam logic [SW-1:0] LAST_SLOT = SW'(NUM_SLOTS - 1);
    localparam logic [PW-1:0] LAST_PH   = PW'(SLOT_CLKS - 1);

    typedef struct packed {
        logic          in_frame;
        logic [CW-1:0] lowcnt;
        logic [SW-1:0] slot;
        logic [PW-1:0] phase;
    } slot_t;

    slot_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d = '0;
        end else if (st_q.in_frame) begin
            st_d.lowcnt = '0;
            if (st_q.phase == LAST_PH) begin
                st_d.phase = '0;
                if (st_q.slot == LAST_SLOT) begin
                    st_d.in_frame = 1'b0;
                    st_d.slot     = '0;
                end else begin
                    st_d.slot = st_q.slot + 1'b1;
                end
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end else if (!pin_i) begin
            if (st_q.lowcnt != START_CNT) st_d.lowcnt = st_q.lowcnt + 1'b1;
        end else begin
            if (st_q.lowcnt == START_CNT) begin
                st_d.in_frame = 1'b1;
                st_d.slot     = '0;
                st_d.phase    = '0;
            end
            st_d.lowcnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign drive_o = enable && want && st_q.in_frame &&
                     (st_q.phase == '0) && (st_q.slot == irq_num);

    p_drive_pulse_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        drive_o |=> !drive_o);

    p_frame_after_high_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.in_frame && !$past(st_q.in_frame)) |-> $past(pin_i));

endmodule

// File: rtl/audio_irq_router.sv
module audio_irq_router
    import audio_irq_pkg::*;
#(
    parameter int NSRC      = 2,
    parameter int MIDI_IDX  = 0,
    parameter int DSP_IDX   = 1,
    parameter int START_MIN = 4,
    parameter int SLOT_CLKS = 3,
    parameter int NUM_SLOTS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_req,
    input  logic [NSRC-1:0] src_ack,
    input  logic [NSRC-1:0] src_en,
    input  logic            uart_fn_en,
    input  logic            legacy_decode,
    input  logic            irq_mode,
    input  logic            serirq_en,
    input  logic [2:0]      route_sel,
    input  logic            sts_wr,
    input  logic [NSRC-1:0] sts_wmask,
    output logic [NSRC-1:0] pend_status,
    output logic [7:0]      dsp_flag,
    output logic            inta_n,
    output logic [NUM_LINES-1:0] irq_lines,
    input  logic            serirq_i,
    output logic            serirq_oe
);

    localparam int SW = $clog2(NUM_SLOTS);
    localparam logic [NSRC-1:0] MIDI_MASK = NSRC'(1) << MIDI_IDX;

    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] eff_en;
    logic            active;
    logic            rvalid;
    proto_e          proto;

    irq_pending_bank #(.NSRC(NSRC)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (src_req),
        .ack   (src_ack),
        .wr    (sts_wr),
        .wmask (sts_wmask),
        .pend  (pend)
    );

    always_comb begin
        eff_en           = src_en;
        eff_en[MIDI_IDX] = src_en[MIDI_IDX] & uart_fn_en & ~legacy_decode;
        active           = |(pend & eff_en);
        rvalid           = route_valid(route_sel);
        if (serirq_en)     proto = PROTO_SERIAL;
        else if (irq_mode) proto = PROTO_LEGACY;
        else               proto = PROTO_LEVEL;

        inta_n = !((proto == PROTO_LEVEL) && active);
        for (int k = 0; k < NUM_LINES; k++) begin
            irq_lines[k] = (proto == PROTO_LEGACY) && active && rvalid &&
                           (route_sel == 3'(k));
        end
        pend_status = pend;
        dsp_flag    = {7'b0, pend[DSP_IDX]};
    end

    irq_serial_slotter #(
        .START_MIN (START_MIN),
        .SLOT_CLKS (SLOT_CLKS),
        .NUM_SLOTS (NUM_SLOTS)
    ) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (proto == PROTO_SERIAL),
        .pin_i   (serirq_i),
        .want    (active && rvalid),
        .irq_num (SW'(route_to_irq(route_sel))),
        .drive_o (serirq_oe)
    );

    p_one_proto_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        !inta_n |-> (irq_lines == '0 && !serirq_oe));

    p_lines_onehot_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_lines));

    p_midi_gate_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        ((legacy_decode || !uart_fn_en) && ((pend_status & src_en & ~MIDI_MASK) == '0))
        |-> (inta_n && irq_lines == '0 && !serirq_oe));

    p_dsp_upper_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        dsp_flag[0] == pend_status[DSP_IDX]);

endmodule

// File: tb/audio_irq_router_test.sv
`timescale 1ns/1ps
module audio_irq_router_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] src_req, src_ack, src_en, sts_wmask;
    logic       uart_fn_en, legacy_decode, irq_mode, serirq_en, sts_wr, serirq_i;
    logic [2:0] route_sel;
    logic [1:0] pend_status;
    logic [7:0] dsp_flag;
    logic       inta_n, serirq_oe;
    logic [4:0] irq_lines;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    audio_irq_router uut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_ack(src_ack),
        .src_en(src_en), .uart_fn_en(uart_fn_en), .legacy_decode(legacy_decode),
        .irq_mode(irq_mode), .serirq_en(serirq_en), .route_sel(route_sel),
        .sts_wr(sts_wr), .sts_wmask(sts_wmask), .pend_status(pend_status),
        .dsp_flag(dsp_flag), .inta_n(inta_n), .irq_lines(irq_lines),
        .serirq_i(serirq_i), .serirq_oe(serirq_oe)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic pulse_req(input logic [1:0] m);
        @(negedge clk) src_req = m;
        @(negedge clk) src_req = '0;
    endtask

    task automatic w1c(input logic [1:0] m);
        @(negedge clk) begin sts_wr = 1'b1; sts_wmask = m; end
        @(negedge clk) begin sts_wr = 1'b0; sts_wmask = '0; end
    endtask

    task automatic t_reset;
        chk("R3 reset pend", pend_status, 0);
        chk("R3 reset dsp_flag", dsp_flag, 0);
        chk("R5 reset inta_n", inta_n, 1);
        chk("R6 reset lines", irq_lines, 0);
        chk("R9 reset oe", serirq_oe, 0);
    endtask

    task automatic t_pending;
        pulse_req(2'b10);
        chk("R1 dsp latched", pend_status, 2'b10);
        chk("R3 dsp flag set", dsp_flag, 8'h01);
        chk("R10 disabled no inta", inta_n, 1);
        @(negedge clk) src_en = 2'b10;
        #1 chk("R10 enable asserts inta", inta_n, 0);
        w1c(2'b01);
        chk("R2 zero mask no effect", pend_status, 2'b10);
        w1c(2'b10);
        chk("R2 w1c clears", pend_status, 0);
        chk("R5 inta released", inta_n, 1);
        chk("R3 dsp flag clear", dsp_flag, 0);
    endtask

    task automatic t_ack_race;
        pulse_req(2'b01);
        chk("R1 midi latched", pend_status, 2'b01);
        @(negedge clk) src_ack = 2'b01;
        @(negedge clk) src_ack = 2'b00;
        chk("R2 ack clears", pend_status, 0);
        @(negedge clk) begin src_req = 2'b10; sts_wr = 1'b1; sts_wmask = 2'b10; end
        @(negedge clk) begin src_req = 2'b00; sts_wr = 1'b0; sts_wmask = 2'b00; end
        chk("R2 set wins over clear", pend_status, 2'b10);
        w1c(2'b10);
    endtask

    task automatic t_midi_gate;
        @(negedge clk) begin src_en = 2'b01; uart_fn_en = 1'b0; legacy_decode = 1'b0; end
        pulse_req(2'b01);
        chk("R7 fn off blocks", inta_n, 1);
        @(negedge clk) begin uart_fn_en = 1'b1; legacy_decode = 1'b1; end
        #1 chk("R7 decode on blocks", inta_n, 1);
        @(negedge clk) legacy_decode = 1'b0;
        #1 chk("R7 gate open asserts", inta_n, 0);
        w1c(2'b01);
        chk("R7 cleared", inta_n, 1);
    endtask

    task automatic t_legacy;
        @(negedge clk) begin irq_mode = 1'b1; src_en = 2'b10; end
        pulse_req(2'b10);
        for (int r = 0; r < 8; r++) begin
            @(negedge clk) route_sel = 3'(r);
            #1 chk("R6 route line", irq_lines, (r < 5) ? (32'd1 << r) : 32'd0);
        end
        chk("R4 legacy no inta", inta_n, 1);
        @(negedge clk) route_sel = 3'd2;
        w1c(2'b10);
        chk("R6 lines low when idle", irq_lines, 0);
    endtask

    task automatic serial_frame(input int lowlen, input int slot, input string req);
        int hits = 0;
        int bad  = 0;
        @(negedge clk) serirq_i = 1'b0;
        repeat (lowlen) @(posedge clk);
        @(negedge clk) serirq_i = 1'b1;
        @(posedge clk);
        for (int c = 0; c < 54; c++) begin
            @(negedge clk);
            if (serirq_oe) hits++;
            if (serirq_oe !== ((slot >= 0) && (c == 3 * slot))) bad++;
            @(posedge clk);
        end
        chk(req, bad, 0);
        chk(req, hits, (slot >= 0) ? 1 : 0);
    endtask

    task automatic t_serial;
        @(negedge clk) begin serirq_en = 1'b1; irq_mode = 1'b0; src_en = 2'b10; route_sel = 3'd0; end
        pulse_req(2'b10);
        chk("R4 serial no inta", inta_n, 1);
        chk("R4 serial no lines", irq_lines, 0);
        serial_frame(4, 5, "R9 slot irq5");
        @(negedge clk) route_sel = 3'd3;
        serial_frame(6, 10, "R9 slot irq10");
        serial_frame(2, -1, "R8 short start ignored");
        @(negedge clk) route_sel = 3'd6;
        serial_frame(4, -1, "R9 invalid route");
        @(negedge clk) route_sel = 3'd4;
        w1c(2'b10);
        serial_frame(4, -1, "R9 no pending no drive");
        pulse_req(2'b10);
        serial_frame(4, 11, "R8 slot irq11");
    endtask

    initial begin
        rst_n = 1'b0; src_req = '0; src_ack = '0; src_en = '0; sts_wmask = '0;
        uart_fn_en = 1'b0; legacy_decode = 1'b0; irq_mode = 1'b0; serirq_en = 1'b0;
        sts_wr = 1'b0; serirq_i = 1'b1; route_sel = 3'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_pending;
        t_ack_race;
        t_midi_gate;
        t_legacy;
        t_serial;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule